// File: doc/BRIEF.md
# Descriptor-Driven Single-Channel DMA Engine

This block moves a programmed number of data elements from one address range to another over a simple request/acknowledge memory port. Software or a neighbouring block writes one 32-bit descriptor word, together with a start source address and a start destination address. The descriptor selects the element size, how far each address moves after every element, how many elements to move, and what happens when the last element is written. Once the descriptor is valid and a trigger is pending, the engine performs one read and then one write of the same data for each element, counting the stored count down as it goes.

When the final element has been written, the descriptor can raise either or both of two sticky interrupt flags and can drop the pending trigger. It can also replace itself with the descriptor and addresses presented on a separate next-descriptor port. Because the trigger stays pending unless the descriptor clears it, reloading allows chained or ping-pong buffers to run back to back without a new trigger. The remaining count is visible on an output for the whole run.

Top module: `dma_desc_engine`

## Requirements
- R1: After synchronous reset the engine is idle: `busy`, `mem_req`, `trig_pend`, `irq_a` and `irq_b` are 0 and `remaining` is 0.
- R2: The descriptor word is decoded as valid bit 0, reload bit 1, software trigger bit 2, clear-trigger bit 3, interrupt-A enable bit 4, interrupt-B enable bit 5, width code bits 9:8, source step code bits 13:12, destination step code bits 15:14 and count bits 25:16. A write on `cfg_we` while idle loads the word and both start addresses and sets the pending trigger to bit 2. A one-cycle `hw_trig` pulse also sets it. A transfer starts only when valid is 1 and a trigger is pending; a descriptor with valid 0 leaves the memory port quiet.
- R3: Width code 3 is reserved: a valid, triggered descriptor with that code makes no memory request.
- R4: A descriptor with count value N performs N+1 elements. Each element is a read at the source address followed by a write of the read data at the destination address. Each request is held, with a stable address, until `mem_ack`.
- R5: `mem_size` equals the width code during every access: 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes.
- R6: After each element, each address advances by its step code times the element size in bytes. Code 0 gives a factor of 0, code 1 gives 1, code 2 gives 2 and code 3 gives 4.
- R7: `remaining` shows the count field. It drops by one when each element's write is acknowledged, so during element k (from 0) it reads N-k.
- R8: On the last write the interrupt flags set whose enable bits are 1. They stay set until a 1 is applied to `irq_clr[0]` (flag A) or `irq_clr[1]` (flag B).
- R9: On the last write, clear-trigger 1 drops `trig_pend`; with clear-trigger 0 it stays set.
- R10: On the last write with reload 1, the descriptor and both addresses are replaced from the next-descriptor port, and the new descriptor starts without a new trigger if one is still pending. With reload 0 the valid bit is cleared, so the channel stays idle.
- R11: `busy` rises with the first read request and falls right after the last write of a descriptor is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load descriptor word and start addresses (taken only while idle) |
| cfg_word | input | 32 | Descriptor word |
| cfg_src | input | AW | Start source address |
| cfg_dst | input | AW | Start destination address |
| hw_trig | input | 1 | Hardware trigger pulse |
| nxt_word | input | 32 | Descriptor used on reload |
| nxt_src | input | AW | Source address used on reload |
| nxt_dst | input | AW | Destination address used on reload |
| irq_clr | input | 2 | Write-one-to-clear for flags A (bit 0) and B (bit 1) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW | Access address |
| mem_size | output | 2 | Access size code |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` on reads |
| mem_ack | input | 1 | Access acknowledge |
| busy | output | 1 | Descriptor in progress |
| remaining | output | 10 | Live count field |
| trig_pend | output | 1 | Trigger pending |
| irq_a | output | 1 | Sticky interrupt flag A |
| irq_b | output | 1 | Sticky interrupt flag B |

## Verification
A descriptor load or a hardware trigger pulse seen at one clock edge puts the first read request out one edge later. Each access completes at the edge where the acknowledge is seen. The count, the addresses, the interrupt flags and the trigger state take their new values at that same edge, and `busy` is low from the following cycle. The bench drives all inputs one time unit after a rising edge and checks there. Its memory model grants and logs accesses on the falling edge, and it waits for several idle cycles in a row before checking the final flags. The address, size, data and remaining-count checks use the log taken while each request was held, so they do not depend on how many cycles each acknowledge takes.

// File: rtl/dma_desc_pkg.sv
package dma_desc_pkg;

    localparam int CNT_W = 10;

    // Field positions are fixed by the descriptor word layout.
    typedef struct packed {
        logic [5:0]       rsv_top;
        logic [CNT_W-1:0] count;
        logic [1:0]       dst_step;
        logic [1:0]       src_step;
        logic [1:0]       rsv_mid;
        logic [1:0]       width;
        logic [1:0]       rsv_low;
        logic             irq_b_en;
        logic             irq_a_en;
        logic             drop_trig;
        logic             sw_trig;
        logic             chain;
        logic             valid;
    } desc_word_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_WRITE = 2'd2
    } eng_state_e;

    localparam logic [1:0] WIDTH_RESERVED = 2'd3;

    function automatic logic width_legal(input logic [1:0] w);
        return w != WIDTH_RESERVED;
    endfunction

    // Bytes added per element: element size scaled by 0, 1, 2 or 4.
    function automatic logic [4:0] step_bytes(input logic [1:0] w, input logic [1:0] code);
        logic [4:0] elem;
        elem = 5'd1 << w;
        case (code)
            2'd0:    return 5'd0;
            2'd1:    return elem;
            2'd2:    return elem << 1;
            default: return elem << 2;
        endcase
    endfunction

endpackage

// File: rtl/dma_trig_latch.sv
module dma_trig_latch (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic load_val,
    input  logic set,
    input  logic clr,
    output logic pend
);
    always_ff @(posedge clk) begin
        if (rst)       pend <= 1'b0;
        else if (load) pend <= load_val | set;
        else if (set)  pend <= 1'b1;
        else if (clr)  pend <= 1'b0;
    end
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          advance,
    input  logic [4:0]    step,
    output logic [AW-1:0] addr
);
    always_ff @(posedge clk) begin
        if (rst)          addr <= '0;
        else if (load)    addr <= load_val;
        else if (advance) addr <= addr + AW'(step);
    end
endmodule

// File: rtl/dma_irq_flags.sv
module dma_irq_flags #(
    parameter int NF = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NF-1:0] set,
    input  logic [NF-1:0] clr,
    output logic [NF-1:0] flags
);
    for (genvar i = 0; i < NF; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)         flags[i] <= 1'b0;
            else if (set[i]) flags[i] <= 1'b1;
            else if (clr[i]) flags[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/dma_desc_engine.sv
module dma_desc_engine
    import dma_desc_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [31:0]      cfg_word,
    input  logic [AW-1:0]    cfg_src,
    input  logic [AW-1:0]    cfg_dst,
    input  logic             hw_trig,
    input  logic [31:0]      nxt_word,
    input  logic [AW-1:0]    nxt_src,
    input  logic [AW-1:0]    nxt_dst,
    input  logic [1:0]       irq_clr,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [1:0]       mem_size,
    output logic [31:0]      mem_wdata,
    input  logic [31:0]      mem_rdata,
    input  logic             mem_ack,
    output logic             busy,
    output logic [CNT_W-1:0] remaining,
    output logic             trig_pend,
    output logic             irq_a,
    output logic             irq_b
);
    localparam int NPTR = 2;   // 0: source, 1: destination

    desc_word_t desc_q, cfg_d, nxt_d;
    eng_state_e state_q;
    logic [31:0] data_q;

    logic accept_cfg, elem_done, last_elem, do_chain, start;
    logic [NPTR-1:0][AW-1:0] ptr_load_val, ptr_addr;
    logic [NPTR-1:0][4:0]    ptr_step;
    logic [1:0] irq_set, irq_q;

    assign cfg_d = desc_word_t'(cfg_word);
    assign nxt_d = desc_word_t'(nxt_word);

    assign accept_cfg = cfg_we && (state_q == ST_IDLE);
    assign elem_done  = (state_q == ST_WRITE) && mem_ack;
    assign last_elem  = elem_done && (desc_q.count == '0);
    assign do_chain   = last_elem && desc_q.chain;
    assign start      = (state_q == ST_IDLE) && !accept_cfg && desc_q.valid
                        && trig_pend && width_legal(desc_q.width);

    // Descriptor register: load, reload, retire or count down.
    always_ff @(posedge clk) begin
        if (rst) begin
            desc_q <= '0;
        end else if (accept_cfg) begin
            desc_q <= cfg_d;
        end else if (last_elem) begin
            if (desc_q.chain) desc_q <= nxt_d;
            else              desc_q.valid <= 1'b0;
        end else if (elem_done) begin
            desc_q.count <= desc_q.count - 1'b1;
        end
    end

    // Read-then-write sequencer.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            data_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE:  if (start) state_q <= ST_READ;
                ST_READ:  if (mem_ack) begin
                              data_q  <= mem_rdata;
                              state_q <= ST_WRITE;
                          end
                ST_WRITE: if (mem_ack) state_q <= last_elem ? ST_IDLE : ST_READ;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    assign ptr_load_val[0] = accept_cfg ? cfg_src : nxt_src;
    assign ptr_load_val[1] = accept_cfg ? cfg_dst : nxt_dst;
    assign ptr_step[0]     = step_bytes(desc_q.width, desc_q.src_step);
    assign ptr_step[1]     = step_bytes(desc_q.width, desc_q.dst_step);

    for (genvar p = 0; p < NPTR; p++) begin : g_ptr
        dma_addr_gen #(.AW(AW)) i_ptr (
            .clk      (clk),
            .rst      (rst),
            .load     (accept_cfg | do_chain),
            .load_val (ptr_load_val[p]),
            .advance  (elem_done),
            .step     (ptr_step[p]),
            .addr     (ptr_addr[p])
        );
    end

    dma_trig_latch i_trig (
        .clk      (clk),
        .rst      (rst),
        .load     (accept_cfg),
        .load_val (cfg_d.sw_trig),
        .set      (hw_trig | (do_chain & nxt_d.sw_trig)),
        .clr      (last_elem & desc_q.drop_trig),
        .pend     (trig_pend)
    );

    assign irq_set = {last_elem & desc_q.irq_b_en, last_elem & desc_q.irq_a_en};

    dma_irq_flags #(.NF(2)) i_irq (
        .clk   (clk),
        .rst   (rst),
        .set   (irq_set),
        .clr   (irq_clr),
        .flags (irq_q)
    );

    assign irq_a     = irq_q[0];
    assign irq_b     = irq_q[1];
    assign mem_req   = (state_q != ST_IDLE);
    assign mem_we    = (state_q == ST_WRITE);
    assign mem_addr  = (state_q == ST_WRITE) ? ptr_addr[1] : ptr_addr[0];
    assign mem_size  = desc_q.width;
    assign mem_wdata = data_q;
    assign busy      = (state_q != ST_IDLE);
    assign remaining = desc_q.count;

endmodule

// File: rtl/dma_desc_chk.sv
module dma_desc_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    irq_clr,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [1:0]    mem_size,
    input logic [31:0]   mem_wdata,
    input logic          mem_ack,
    input logic          busy,
    input logic [9:0]    remaining,
    input logic          irq_a,
    input logic          irq_b
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R4

    AST_WDATA_HELD: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we && !mem_ack |=> $stable(mem_wdata)); // R4

    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_we && mem_ack |=> mem_req && mem_we); // R4

    AST_NO_RESERVED_SIZE: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> mem_size != 2'd3); // R3

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we && mem_ack && remaining != 10'd0
        |=> remaining == $past(remaining) - 10'd1); // R7

    AST_IRQ_A_STICKY: assert property (@(posedge clk) disable iff (rst)
        irq_a && !irq_clr[0] |=> irq_a); // R8

    AST_IRQ_B_STICKY: assert property (@(posedge clk) disable iff (rst)
        irq_b && !irq_clr[1] |=> irq_b); // R8

    AST_BUSY_ENDS_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(mem_we && mem_ack)); // R11
endmodule

bind dma_desc_engine dma_desc_chk #(.AW(AW)) i_dma_desc_chk (
    .clk       (clk),
    .rst       (rst),
    .irq_clr   (irq_clr),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_size  (mem_size),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .busy      (busy),
    .remaining (remaining),
    .irq_a     (irq_a),
    .irq_b     (irq_b)
);

// File: tb/test_dma_desc_engine.sv
module test_dma_desc_engine;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int LOGN = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [31:0] cfg_word = '0;
    logic [AW-1:0] cfg_src = '0, cfg_dst = '0;
    logic hw_trig = 1'b0;
    logic [31:0] nxt_word = '0;
    logic [AW-1:0] nxt_src = '0, nxt_dst = '0;
    logic [1:0] irq_clr = '0;
    logic mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [1:0] mem_size;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic mem_ack = 1'b0;
    logic busy, trig_pend, irq_a, irq_b;
    logic [9:0] remaining;

    int n_checks = 0;
    int n_fail = 0;

    logic        lg_we   [LOGN];
    logic [31:0] lg_addr [LOGN];
    logic [31:0] lg_data [LOGN];
    logic [1:0]  lg_size [LOGN];
    logic [9:0]  lg_rem  [LOGN];
    logic        lg_busy [LOGN];
    int n_log = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_desc_engine #(.AW(AW)) i_dma_desc_engine (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_word(cfg_word),
        .cfg_src(cfg_src), .cfg_dst(cfg_dst), .hw_trig(hw_trig),
        .nxt_word(nxt_word), .nxt_src(nxt_src), .nxt_dst(nxt_dst),
        .irq_clr(irq_clr), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .busy(busy),
        .remaining(remaining), .trig_pend(trig_pend), .irq_a(irq_a), .irq_b(irq_b)
    );

    function automatic logic [31:0] pattern(input logic [31:0] a);
        return 32'hC0DE_0000 ^ a;
    endfunction

    // Memory model: grants on the falling edge, one access per two cycles.
    always @(negedge clk) begin
        if (rst) begin
            mem_ack = 1'b0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (n_log < LOGN) begin
                lg_we[n_log]   = mem_we;
                lg_addr[n_log] = mem_addr;
                lg_data[n_log] = mem_we ? mem_wdata : pattern(mem_addr);
                lg_size[n_log] = mem_size;
                lg_rem[n_log]  = remaining;
                lg_busy[n_log] = busy;
                n_log++;
            end
            mem_rdata = pattern(mem_addr);
            mem_ack = 1'b1;
        end
    end

    task automatic chk(input logic ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit v, input bit rl, input bit sw, input bit clr,
                                       input bit ia, input bit ib, input int w,
                                       input int si, input int di, input int cnt);
        logic [31:0] x;
        x = '0;
        x[0] = v; x[1] = rl; x[2] = sw; x[3] = clr; x[4] = ia; x[5] = ib;
        x[9:8] = 2'(w); x[13:12] = 2'(si); x[15:14] = 2'(di); x[25:16] = 10'(cnt);
        return x;
    endfunction

    function automatic int step_of(input int w, input int code);
        int f;
        f = (code == 0) ? 0 : (code == 1) ? 1 : (code == 2) ? 2 : 4;
        return f * (1 << w);
    endfunction

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic load_desc(input logic [31:0] w, input logic [31:0] s, input logic [31:0] d);
        n_log = 0;
        cfg_word = w; cfg_src = s; cfg_dst = d; cfg_we = 1'b1;
        tick(1);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_hw;
        hw_trig = 1'b1;
        tick(1);
        hw_trig = 1'b0;
    endtask

    task automatic wait_idle;
        int quiet = 0;
        for (int i = 0; i < 4000; i++) begin
            tick(1);
            if (busy) quiet = 0; else quiet++;
            if (quiet >= 6) break;
        end
    endtask

    // Checks log entries from base for one descriptor run.
    task automatic check_run(input string req, input int base, input logic [31:0] s,
                             input logic [31:0] d, input int w, input int si,
                             input int di, input int cnt);
        int ss = step_of(w, si);
        int ds = step_of(w, di);
        for (int k = 0; k <= cnt; k++) begin
            int r = base + 2*k;
            logic [31:0] sa = s + 32'(k*ss);
            logic [31:0] da = d + 32'(k*ds);
            chk(!lg_we[r] && lg_addr[r] == sa, req, "read address", lg_addr[r], sa);
            chk(lg_we[r+1] && lg_addr[r+1] == da, req, "write address", lg_addr[r+1], da);
            chk(lg_data[r+1] == pattern(sa), "R4", "write data", lg_data[r+1], pattern(sa));
            chk(lg_size[r] == 2'(w) && lg_size[r+1] == 2'(w), "R5", "size", lg_size[r+1], w);
            chk(lg_rem[r+1] == 10'(cnt-k), "R7", "remaining", lg_rem[r+1], cnt-k);
            chk(lg_busy[r] && lg_busy[r+1], "R11", "busy during access", lg_busy[r], 1);
        end
    endtask

    task automatic t_reset;
        chk(!busy && !mem_req && !trig_pend, "R1", "idle after reset",
            {busy, mem_req, trig_pend}, 0);
        chk(!irq_a && !irq_b && remaining == 0, "R1", "flags/count after reset",
            {irq_a, irq_b, remaining}, 0);
    endtask

    task automatic t_gate_and_hw;
        load_desc(mk(0,0,1,0,0,0,2,1,1,2), 32'h1000, 32'h2000);
        tick(10);
        chk(n_log == 0, "R2", "invalid descriptor accesses", n_log, 0);
        chk(trig_pend == 1'b1, "R2", "software trigger pending", trig_pend, 1);
        load_desc(mk(1,0,0,1,1,0,2,1,1,2), 32'h1000, 32'h2000);
        tick(10);
        chk(n_log == 0 && !trig_pend, "R2", "valid but no trigger", n_log, 0);
        pulse_hw();
        wait_idle();
        chk(n_log == 6, "R4", "access count for count=2", n_log, 6);
        check_run("R6", 0, 32'h1000, 32'h2000, 2, 1, 1, 2);
        chk(irq_a && !irq_b, "R8", "only flag A", {irq_a, irq_b}, 2'b10);
        chk(!busy && remaining == 0, "R11", "idle at end", {busy, remaining}, 0);
        irq_clr = 2'b10; tick(1); irq_clr = 2'b00;
        chk(irq_a, "R8", "clear B leaves A", irq_a, 1);
        irq_clr = 2'b01; tick(1); irq_clr = 2'b00;
        chk(!irq_a, "R8", "flag A cleared", irq_a, 0);
    endtask

    task automatic t_reserved_width;
        load_desc(mk(1,0,1,0,1,1,3,1,1,1), 32'h10, 32'h20);
        tick(12);
        chk(n_log == 0 && !busy, "R3", "reserved width accesses", n_log, 0);
        chk(!irq_a && !irq_b, "R3", "no flags for reserved width", {irq_a, irq_b}, 0);
    endtask

    task automatic t_byte_fixed_src;
        load_desc(mk(1,0,1,1,0,1,0,0,3,3), 32'h0000_4001, 32'h0000_5003);
        wait_idle();
        chk(n_log == 8, "R4", "access count for count=3", n_log, 8);
        check_run("R6", 0, 32'h4001, 32'h5003, 0, 0, 3, 3);
        chk(irq_b && !irq_a, "R8", "only flag B", {irq_a, irq_b}, 2'b01);
        chk(!trig_pend, "R9", "trigger dropped", trig_pend, 0);
        irq_clr = 2'b10; tick(1); irq_clr = 2'b00;
        chk(!irq_b, "R8", "flag B cleared", irq_b, 0);
    endtask

    task automatic t_half_keep_trig;
        load_desc(mk(1,0,1,0,0,0,1,2,1,1), 32'h600, 32'h700);
        wait_idle();
        tick(10);
        chk(n_log == 4, "R10", "no rerun after retire", n_log, 4);
        check_run("R6", 0, 32'h600, 32'h700, 1, 2, 1, 1);
        chk(trig_pend, "R9", "trigger kept", trig_pend, 1);
    endtask

    task automatic t_chain;
        nxt_word = mk(1,0,0,1,1,0,2,1,1,0);
        nxt_src = 32'h300; nxt_dst = 32'h400;
        load_desc(mk(1,1,1,0,0,0,2,1,1,1), 32'h100, 32'h200);
        wait_idle();
        chk(n_log == 6, "R10", "chained access count", n_log, 6);
        check_run("R10", 0, 32'h100, 32'h200, 2, 1, 1, 1);
        check_run("R10", 4, 32'h300, 32'h400, 2, 1, 1, 0);
        chk(irq_a && !trig_pend, "R10", "second descriptor ending", {irq_a, trig_pend}, 2'b10);
        irq_clr = 2'b11; tick(1); irq_clr = 2'b00;
        // Chain with the trigger dropped: next descriptor waits for a pulse.
        nxt_word = mk(1,0,0,0,0,1,0,1,0,0);
        nxt_src = 32'h900; nxt_dst = 32'hA00;
        load_desc(mk(1,1,1,1,0,0,0,1,1,0), 32'h800, 32'h880);
        wait_idle();
        tick(8);
        chk(n_log == 2 && !irq_b, "R9", "reloaded waits for trigger", n_log, 2);
        pulse_hw();
        wait_idle();
        chk(n_log == 4, "R10", "reloaded runs after pulse", n_log, 4);
        check_run("R10", 2, 32'h900, 32'hA00, 0, 1, 0, 0);
        chk(irq_b, "R8", "flag B from reloaded", irq_b, 1);
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        t_reset();
        t_gate_and_hw();
        t_reserved_width();
        t_byte_fixed_src();
        t_half_keep_trig();
        t_chain();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule